// File: doc/BRIEF.md
# Banked Scratchpad RAM with Bit Operations

This block holds the 128-byte on-chip data memory of a small 8-bit controller core. It has three access ports, and each can be used in every cycle. The byte port reaches any location directly. The register port takes a register number from 0 to 7 and a two-bit bank selector. The bank selector comes from bits 4 and 3 of the controller's status word. The port turns this pair into a location in the lowest 32 bytes. The bit port takes a 7-bit bit address and reads, sets or clears one bit in the 16-byte region at 20h–2Fh. A set or clear changes only that bit and leaves the rest of the byte as it was.

The storage array has no reset of its own. After reset, a sequencer writes zero into one byte per clock. The `ready` output stays low until all 128 bytes have been written. While `ready` is low, every request is ignored. Reads on all ports return the stored value from before the writes of the same cycle, one clock after the request. This holds for set and clear too, so a set or clear also reports the old bit. When two ports write the same byte in one cycle, the byte port wins.

Top module: `iram_banked_bitmem`

## Requirements
- R1: While `rst_n` is low and right after it is released, `ready` is 0 and `byte_rdata`, `reg_rdata` and `bit_rdata` are all 0. Once `ready` is 1 it stays 1 until the next reset.
- R2: `ready` rises on the 128th rising clock edge after `rst_n` goes high. From then on, every one of the 128 bytes reads as 00h until it is written.
- R3: A request on any port while `ready` is 0 writes nothing and leaves all three read outputs unchanged.
- R4: When `byte_en` is 1, `byte_rdata` shows the byte at `byte_addr` as it was before that cycle's writes, one clock later. With `byte_we` also 1, `byte_wdata` is stored there. `byte_rdata` holds its value in cycles where `byte_en` is 0.
- R5: The register port reaches physical address 8×`rbank_sel` + `reg_num`. Bank 0 is 00h–07h, bank 1 is 08h–0Fh, bank 2 is 10h–17h and bank 3 is 18h–1Fh.
- R6: When `reg_en` is 1, `reg_rdata` shows the old content of the mapped register one clock later. With `reg_we` also 1, `reg_wdata` is stored in that register.
- R7: Bit address b selects byte 20h + b[6:3] and bit position b[2:0] within that byte. Bit address 00h is bit 0 of 20h, and 7Fh is bit 7 of 2Fh.
- R8: `bit_op` codes are: 00 = read, 01 = set, 10 = clear, 11 = read. When `bit_en` is 1, `bit_rdata` shows the bit's value before the operation, one clock later. A set or clear changes only the addressed bit.
- R9: When the byte port writes the same byte as a register write or a bit set/clear in the same cycle, the byte port's data is what ends up stored. Writes from different ports to different bytes in one cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ready | output | 1 | High once the clearing pass has finished |
| byte_en | input | 1 | Byte port request |
| byte_we | input | 1 | Byte port write |
| byte_addr | input | 7 | Byte port address |
| byte_wdata | input | 8 | Byte port write data |
| byte_rdata | output | 8 | Byte port read data (old content) |
| rbank_sel | input | 2 | Bank selector, taken from status word bits 4:3 |
| reg_num | input | 3 | Register number within the bank |
| reg_en | input | 1 | Register port request |
| reg_we | input | 1 | Register port write |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Register port read data (old content) |
| bit_en | input | 1 | Bit port request |
| bit_op | input | 2 | Bit operation: 00 read, 01 set, 10 clear, 11 read |
| bit_addr | input | 7 | Bit address in the 20h–2Fh region |
| bit_rdata | output | 1 | Bit value before the operation |

## Verification
The bench keeps requests active through the clock edge on which `ready` rises. A design that opened the ports one cycle early would store that late write, and the bench would then read it back as non-zero. The extreme bit addresses 00h and 7Fh are tested, along with a set on a bit that is already set and a clear followed by a test. A design that swapped the byte and bit index fields, or merged a set into the whole byte, would read back the wrong pattern in 20h–2Fh. The bench also aims same-cycle byte writes at a register and at a bit-region byte. A wrong write priority would leave the register or bit data in place instead of the byte data. It also checks that reads return the value from before the write, so a design that forwarded write data would report the new value.

// File: rtl/iram_pkg.sv
package iram_pkg;

    localparam int IRAM_DEPTH     = 128;
    localparam int IRAM_DW        = 8;
    localparam int IRAM_REGS      = 8;
    localparam int IRAM_BANKS     = 4;
    localparam int IRAM_BIT_BASE  = 32;
    localparam int IRAM_BIT_BYTES = 16;

    typedef enum logic [1:0] {
        BOP_READ  = 2'b00,
        BOP_SET   = 2'b01,
        BOP_CLEAR = 2'b10,
        BOP_TEST  = 2'b11
    } bitop_e;

endpackage

// File: rtl/iram_addr_map.sv
module iram_addr_map #(
    parameter int DW        = iram_pkg::IRAM_DW,
    parameter int DEPTH     = iram_pkg::IRAM_DEPTH,
    parameter int REGS      = iram_pkg::IRAM_REGS,
    parameter int BANKS     = iram_pkg::IRAM_BANKS,
    parameter int BIT_BASE  = iram_pkg::IRAM_BIT_BASE,
    parameter int BIT_BYTES = iram_pkg::IRAM_BIT_BYTES,
    localparam int AW       = $clog2(DEPTH),
    localparam int NW       = $clog2(REGS),
    localparam int KW       = $clog2(BANKS),
    localparam int PW       = $clog2(DW),
    localparam int BW       = $clog2(BIT_BYTES * DW)
) (
    input  logic [KW-1:0] bank_sel,
    input  logic [NW-1:0] reg_num,
    input  logic [BW-1:0] bit_addr,
    output logic [AW-1:0] reg_phys,
    output logic [AW-1:0] bit_byte,
    output logic [PW-1:0] bit_pos
);

    localparam logic [AW-1:0] BIT_BASE_A = AW'(BIT_BASE);

    always_comb begin
        // banks are laid out back to back, REGS bytes each
        reg_phys = AW'({bank_sel, reg_num});
        // upper bit-address field picks the byte, lower field the bit
        bit_byte = BIT_BASE_A + AW'(bit_addr[BW-1:PW]);
        bit_pos  = bit_addr[PW-1:0];
    end

endmodule

// File: rtl/iram_init_seq.sv
module iram_init_seq #(
    parameter int DEPTH = iram_pkg::IRAM_DEPTH,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          clr_we,
    output logic [AW-1:0] clr_addr,
    output logic          ready
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          busy;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            s_d.ptr = s_q.ptr + 1'b1;
            if (s_q.ptr == LAST) begin
                s_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ptr: '0, busy: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign clr_we   = s_q.busy;
    assign clr_addr = s_q.ptr;
    assign ready    = ~s_q.busy;

endmodule

// File: rtl/iram_core.sv
module iram_core #(
    parameter int DEPTH = iram_pkg::IRAM_DEPTH,
    parameter int DW    = iram_pkg::IRAM_DW,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = $clog2(DW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_we,
    input  logic [AW-1:0]        clr_addr,
    input  logic                 acc_ok,
    input  logic                 b_en,
    input  logic                 b_we,
    input  logic [AW-1:0]        b_addr,
    input  logic [DW-1:0]        b_wdata,
    input  logic                 r_en,
    input  logic                 r_we,
    input  logic [AW-1:0]        r_addr,
    input  logic [DW-1:0]        r_wdata,
    input  logic                 t_en,
    input  iram_pkg::bitop_e     t_op,
    input  logic [AW-1:0]        t_byte,
    input  logic [PW-1:0]        t_pos,
    output logic [DW-1:0]        b_rdata,
    output logic [DW-1:0]        r_rdata,
    output logic                 t_rdata
);
    import iram_pkg::*;

    typedef struct packed {
        logic [DW-1:0] bval;
        logic [DW-1:0] rval;
        logic          tval;
    } rd_t;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];
    rd_t           rd_d, rd_q;

    always_comb begin
        mem_d = mem_q;
        rd_d  = rd_q;
        if (clr_we) begin
            mem_d[clr_addr] = '0;
        end else if (acc_ok) begin
            // every read sees the array before this cycle's writes
            if (b_en) rd_d.bval = mem_q[b_addr];
            if (r_en) rd_d.rval = mem_q[r_addr];
            if (t_en) rd_d.tval = mem_q[t_byte][t_pos];
            // lowest priority first, byte port applied last
            if (t_en) begin
                unique case (t_op)
                    BOP_SET:   mem_d[t_byte][t_pos] = 1'b1;
                    BOP_CLEAR: mem_d[t_byte][t_pos] = 1'b0;
                    default:   ;
                endcase
            end
            if (r_en && r_we) mem_d[r_addr] = r_wdata;
            if (b_en && b_we) mem_d[b_addr] = b_wdata;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign b_rdata = rd_q.bval;
    assign r_rdata = rd_q.rval;
    assign t_rdata = rd_q.tval;

endmodule

// File: rtl/iram_banked_bitmem.sv
module iram_banked_bitmem #(
    parameter int DEPTH     = iram_pkg::IRAM_DEPTH,
    parameter int DW        = iram_pkg::IRAM_DW,
    parameter int REGS      = iram_pkg::IRAM_REGS,
    parameter int BANKS     = iram_pkg::IRAM_BANKS,
    parameter int BIT_BASE  = iram_pkg::IRAM_BIT_BASE,
    parameter int BIT_BYTES = iram_pkg::IRAM_BIT_BYTES,
    localparam int AW       = $clog2(DEPTH),
    localparam int NW       = $clog2(REGS),
    localparam int KW       = $clog2(BANKS),
    localparam int PW       = $clog2(DW),
    localparam int BW       = $clog2(BIT_BYTES * DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          ready,
    input  logic          byte_en,
    input  logic          byte_we,
    input  logic [AW-1:0] byte_addr,
    input  logic [DW-1:0] byte_wdata,
    output logic [DW-1:0] byte_rdata,
    input  logic [KW-1:0] rbank_sel,
    input  logic [NW-1:0] reg_num,
    input  logic          reg_en,
    input  logic          reg_we,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          bit_en,
    input  logic [1:0]    bit_op,
    input  logic [BW-1:0] bit_addr,
    output logic          bit_rdata
);
    import iram_pkg::*;

    logic          clr_we;
    logic [AW-1:0] clr_addr;
    logic [AW-1:0] reg_phys;
    logic [AW-1:0] bit_byte;
    logic [PW-1:0] bit_pos;
    bitop_e        op_e;

    assign op_e = bitop_e'(bit_op);

    iram_addr_map #(
        .DW(DW), .DEPTH(DEPTH), .REGS(REGS), .BANKS(BANKS),
        .BIT_BASE(BIT_BASE), .BIT_BYTES(BIT_BYTES)
    ) u_map (
        .bank_sel (rbank_sel),
        .reg_num  (reg_num),
        .bit_addr (bit_addr),
        .reg_phys (reg_phys),
        .bit_byte (bit_byte),
        .bit_pos  (bit_pos)
    );

    iram_init_seq #(.DEPTH(DEPTH)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (clr_we),
        .clr_addr (clr_addr),
        .ready    (ready)
    );

    iram_core #(.DEPTH(DEPTH), .DW(DW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (clr_we),
        .clr_addr (clr_addr),
        .acc_ok   (ready),
        .b_en     (byte_en),
        .b_we     (byte_we),
        .b_addr   (byte_addr),
        .b_wdata  (byte_wdata),
        .r_en     (reg_en),
        .r_we     (reg_we),
        .r_addr   (reg_phys),
        .r_wdata  (reg_wdata),
        .t_en     (bit_en),
        .t_op     (op_e),
        .t_byte   (bit_byte),
        .t_pos    (bit_pos),
        .b_rdata  (byte_rdata),
        .r_rdata  (reg_rdata),
        .t_rdata  (bit_rdata)
    );

endmodule

// File: rtl/iram_banked_bitmem_chk.sv
module iram_banked_bitmem_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ready,
    input logic       byte_en,
    input logic       byte_we,
    input logic [6:0] byte_addr,
    input logic [7:0] byte_wdata,
    input logic [7:0] byte_rdata,
    input logic [1:0] rbank_sel,
    input logic [2:0] reg_num,
    input logic       reg_en,
    input logic       reg_we,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       bit_en,
    input logic [1:0] bit_op,
    input logic [6:0] bit_addr,
    input logic       bit_rdata
);

    logic [6:0] exp_reg_loc;
    logic [6:0] exp_bit_loc;
    assign exp_reg_loc = {2'b00, rbank_sel, reg_num};
    assign exp_bit_loc = 7'h20 + {3'b000, bit_addr[6:3]};

    // R1: ready never drops once raised
    a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R3: no read output moves before ready
    a_r3_outputs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(byte_rdata) && $stable(reg_rdata) && $stable(bit_rdata)));

    // R4: byte read data holds when the port is idle
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !byte_en) |=> $stable(byte_rdata));

    // R5: a register write is visible at its mapped byte address
    a_r5_reg_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && byte_en && byte_addr == $past(exp_reg_loc)
         && $past(ready && reg_en && reg_we
                  && !(byte_en && byte_we && byte_addr == exp_reg_loc)))
        |=> byte_rdata == $past(reg_wdata, 2));

    // R8: a set bit reads back as one on the next access
    a_r8_set_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && bit_en && (bit_op == 2'b00 || bit_op == 2'b11)
         && bit_addr == $past(bit_addr)
         && $past(ready && bit_en && bit_op == 2'b01
                  && !(byte_en && byte_we && byte_addr == exp_bit_loc)))
        |=> bit_rdata);

    // R9: byte write beats a bit operation on the same byte
    a_r9_byte_beats_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && byte_en && byte_addr == $past(byte_addr)
         && $past(ready && byte_en && byte_we && bit_en && byte_addr == exp_bit_loc))
        |=> byte_rdata == $past(byte_wdata, 2));

endmodule

bind iram_banked_bitmem iram_banked_bitmem_chk u_chk (.*);

// File: tb/tb_iram_banked_bitmem.sv
module tb_iram_banked_bitmem;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ready;
    logic       byte_en = 1'b0, byte_we = 1'b0;
    logic [6:0] byte_addr = '0;
    logic [7:0] byte_wdata = '0, byte_rdata;
    logic [1:0] rbank_sel = '0;
    logic [2:0] reg_num = '0;
    logic       reg_en = 1'b0, reg_we = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       bit_en = 1'b0;
    logic [1:0] bit_op = '0;
    logic [6:0] bit_addr = '0;
    logic       bit_rdata;

    iram_banked_bitmem dut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int         port;
        logic [7:0] exp;
        string      req;
    } exp_t;

    exp_t       sbq[$];
    logic [7:0] model [128];
    int         checks = 0;
    int         fails = 0;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compare every result produced at the previous edge
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            exp_t it;
            logic [7:0] act;
            it = sbq.pop_front();
            case (it.port)
                0:       act = byte_rdata;
                1:       act = reg_rdata;
                default: act = {7'b0, bit_rdata};
            endcase
            chk(it.req, act, it.exp);
        end
    end

    // driver: one cycle with any mix of ports, expected results pushed
    task automatic xact(input bit be, input bit bw, input logic [6:0] ba, input logic [7:0] bd,
                        input bit re, input bit rw, input logic [1:0] bk, input logic [2:0] rn,
                        input logic [7:0] rd, input bit te, input logic [1:0] op,
                        input logic [6:0] ta, input string tag);
        exp_t       items[$];
        int         ra, tb, tp;
        byte_en = be; byte_we = bw; byte_addr = ba; byte_wdata = bd;
        reg_en = re; reg_we = rw; rbank_sel = bk; reg_num = rn; reg_wdata = rd;
        bit_en = te; bit_op = op; bit_addr = ta;
        ra = int'(bk) * 8 + int'(rn);
        tb = 32 + int'(ta) / 8;
        tp = int'(ta) % 8;
        if (be) items.push_back('{0, model[ba], tag});
        if (re) items.push_back('{1, model[ra], tag});
        if (te) items.push_back('{2, {7'b0, model[tb][tp]}, tag});
        if (te && op == 2'b01) model[tb][tp] = 1'b1;
        if (te && op == 2'b10) model[tb][tp] = 1'b0;
        if (re && rw) model[ra] = rd;
        if (be && bw) model[ba] = bd;
        @(posedge clk);
        foreach (items[i]) sbq.push_back(items[i]);
        @(negedge clk);
        byte_en = 1'b0; reg_en = 1'b0; bit_en = 1'b0;
    endtask

    task automatic byte_wr(input logic [6:0] a, input logic [7:0] d, input string tag);
        xact(1, 1, a, d, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic byte_rd(input logic [6:0] a, input string tag);
        xact(1, 0, a, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic reg_wr(input logic [1:0] bk, input logic [2:0] n, input logic [7:0] d, input string tag);
        xact(0, 0, 0, 0, 1, 1, bk, n, d, 0, 0, 0, tag);
    endtask
    task automatic reg_rd(input logic [1:0] bk, input logic [2:0] n, input string tag);
        xact(0, 0, 0, 0, 1, 0, bk, n, 0, 0, 0, 0, tag);
    endtask
    task automatic bit_do(input logic [1:0] op, input logic [6:0] a, input string tag);
        xact(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, op, a, tag);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        foreach (model[i]) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", {7'b0, ready}, 8'h00);
        chk("R1", byte_rdata, 8'h00);
        chk("R1", reg_rdata, 8'h00);
        chk("R1", {7'b0, bit_rdata}, 8'h00);
        rst_n = 1'b1;
        // R3: requests held active across the whole clearing pass
        byte_en = 1; byte_we = 1; byte_addr = 7'h06; byte_wdata = 8'hAA;
        reg_en = 1; reg_we = 1; rbank_sel = 2'd0; reg_num = 3'd5; reg_wdata = 8'h77;
        bit_en = 1; bit_op = 2'b01; bit_addr = 7'h00;
        for (int k = 1; k <= 128; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 1) chk("R1", {7'b0, ready}, 8'h00);
            if (k == 127) begin
                chk("R2", {7'b0, ready}, 8'h00);
                chk("R3", byte_rdata, 8'h00);
                chk("R3", reg_rdata, 8'h00);
                chk("R3", {7'b0, bit_rdata}, 8'h00);
            end
        end
        chk("R2", {7'b0, ready}, 8'h01);
        byte_en = 0; reg_en = 0; bit_en = 0;
        @(negedge clk);
        chk("R1", {7'b0, ready}, 8'h01);

        // R2 / R3: whole array zero, including the locations hit during clearing
        for (int a = 0; a < 128; a++) begin
            byte_rd(7'(a), (a == 6 || a == 5 || a == 32) ? "R3" : "R2");
        end

        // R4: byte writes in the general area, old value returned on write
        for (int a = 48; a < 128; a += 9) byte_wr(7'(a), 8'((a * 7 + 3) ^ 8'h5A), "R4");
        byte_wr(7'h30, 8'hC3, "R4");
        for (int a = 48; a < 128; a += 9) byte_rd(7'(a), "R4");
        byte_rd(7'h7F, "R4");
        byte_rd(7'h30, "R4");
        repeat (2) @(negedge clk);
        chk("R4", byte_rdata, model[7'h30]);

        // R5 / R6: every register of every bank
        for (int b = 0; b < 4; b++)
            for (int n = 0; n < 8; n++)
                reg_wr(2'(b), 3'(n), 8'(8'h80 + b * 16 + n), "R6");
        for (int a = 0; a < 32; a++) byte_rd(7'(a), "R5");
        reg_rd(2'd3, 3'd7, "R6");
        reg_rd(2'd1, 3'd0, "R6");
        reg_rd(2'd2, 3'd4, "R6");
        reg_wr(2'd2, 3'd4, 8'h3C, "R6");
        reg_rd(2'd2, 3'd4, "R6");
        byte_rd(7'h14, "R5");

        // R7 / R8: bit operations at the region ends and inside
        bit_do(2'b01, 7'h00, "R8");
        bit_do(2'b01, 7'h7F, "R8");
        bit_do(2'b01, 7'h13, "R8");
        bit_do(2'b01, 7'h13, "R8");
        bit_do(2'b01, 7'h45, "R8");
        for (int a = 32; a < 48; a++) byte_rd(7'(a), "R7");
        bit_do(2'b00, 7'h7F, "R8");
        bit_do(2'b10, 7'h13, "R8");
        bit_do(2'b11, 7'h13, "R8");
        byte_wr(7'h2A, 8'hFF, "R4");
        bit_do(2'b10, 7'h53, "R8");
        byte_rd(7'h2A, "R8");
        byte_rd(7'h22, "R7");

        // R9: same-byte conflicts and independent writes
        xact(1, 1, 7'h22, 8'h0F, 0, 0, 0, 0, 0, 1, 2'b10, 7'h10, "R9");
        byte_rd(7'h22, "R9");
        xact(1, 1, 7'h0A, 8'h5E, 1, 1, 2'd1, 3'd2, 8'hE1, 0, 0, 0, "R9");
        byte_rd(7'h0A, "R9");
        xact(1, 1, 7'h21, 8'h81, 1, 1, 2'd0, 3'd1, 8'h42, 1, 2'b01, 7'h72, "R9");
        byte_rd(7'h21, "R9");
        byte_rd(7'h01, "R9");
        byte_rd(7'h2E, "R9");

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule